// File: doc/BRIEF.md
# Input/Output Shift Unit with Threshold-Driven Push and Pull

This block holds the two shift registers of a programmable I/O sequencer. The input register collects bits that IN operations shift in from a source word. The output register feeds OUT operations, which shift bits out of it. Each register has its own bit counter and its own shift direction. Each also has a threshold that decides when the register counts as full (for input) or spent (for output).

The unit talks to a receive FIFO through a push port and to a transmit FIFO through a pull port. Pushes and pulls happen in three ways:
- from explicit PUSH and PULL operations;
- conditionally, only once the matching threshold is reached;
- automatically, as a side effect of IN and OUT.

When an operation must wait on a FIFO, the unit raises `stall`, leaves its state alone and expects the issuer to hold the same operation until it completes. A restart input clears the input side and both counters but keeps the output word.

Top module: `shift_unit`

## Requirements
- R1: After reset the input and output registers and both counters read zero, and `stall`, `rx_push` and `tx_pull` are low.
- R2: IN takes n bits (an `op_bits` value of 0 means 32). With `in_shr`=0 the register shifts left and the new bits enter at the LSB end. With `in_shr`=1 it shifts right and the new bits enter at the MSB end. The input counter grows by n.
- R3: An `in_count` value k forces source bits k and above to zero before IN uses them. A value of 0 masks nothing.
- R4: OUT returns n bits right-aligned on `out_data`. With `out_shr`=1 the bits come from the LSB end of the output register, and with `out_shr`=0 they come from the MSB end. The register then shifts in the same direction by n, and the output counter grows by n.
- R5: With `auto_push` set, an IN that brings the input counter to the push threshold or above pushes the shifted word. The input register and its counter then become zero. A threshold field of 0 means 32.
- R6: An IN that needs an automatic push while `rx_full` is high raises `stall`, does not complete, and changes no state.
- R7: With `auto_pull` set, an OUT that brings the output counter to the pull threshold or above reloads the register from `tx_data` and zeroes its counter, if the transmit FIFO is not empty. If the FIFO is empty the OUT still completes. A later OUT that finds the counter at the threshold then stalls while the FIFO is empty, and otherwise reloads first and shifts from the fresh word.
- R8: A PUSH with `op_cond` set does nothing while the input counter is below the push threshold. A PULL with `op_cond` set does nothing while the output counter is below the pull threshold.
- R9: A PUSH pushes the input word and clears it. A PULL loads `tx_data` and zeroes the output counter. If the FIFO is full (for PUSH) or empty (for PULL), a blocking operation stalls. A non-blocking PUSH then drops the word and clears the input side. A non-blocking PULL then leaves the output register unchanged.
- R10: `restart` clears the input register and both counters, keeps the output register, and overrides any operation in the same cycle.
- R11: Both counters saturate at 32.

Operation codes on `op_kind`: 0 = IN, 1 = OUT, 2 = PUSH, 3 = PULL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | Clear input side and counters |
| in_shr | input | 1 | Input shift direction, 1 = right |
| out_shr | input | 1 | Output shift direction, 1 = right |
| auto_push | input | 1 | Enable automatic push on IN |
| auto_pull | input | 1 | Enable automatic reload on OUT |
| push_th | input | 5 | Push threshold, 0 = 32 |
| pull_th | input | 5 | Pull threshold, 0 = 32 |
| in_count | input | 5 | Visible source bits, 0 = 32 |
| op_valid | input | 1 | Operation present |
| op_kind | input | 2 | 0 IN, 1 OUT, 2 PUSH, 3 PULL |
| op_bits | input | 5 | Bit count for IN/OUT, 0 = 32 |
| op_data | input | 32 | Source word for IN |
| op_block | input | 1 | PUSH/PULL waits on FIFO |
| op_cond | input | 1 | PUSH/PULL only at threshold |
| op_done | output | 1 | Operation completes this cycle |
| stall | output | 1 | Operation waits on a FIFO |
| out_data | output | 32 | OUT result |
| rx_full | input | 1 | Receive FIFO full |
| rx_push | output | 1 | Write strobe to receive FIFO |
| rx_data | output | 32 | Word pushed to receive FIFO |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | 32 | Head word of transmit FIFO |
| tx_pull | output | 1 | Read strobe to transmit FIFO |
| isr_o | output | 32 | Input shift register |
| osr_o | output | 32 | Output shift register |
| isr_cnt_o | output | 6 | Input bit counter |
| osr_cnt_o | output | 6 | Output bit counter |

## Verification
The strobes and data results (`op_done`, `stall`, `rx_push`, `rx_data`, `tx_pull`, `out_data`) are combinational and due in the same cycle as the operation. The registers and counters show the result one rising edge later. The bench drives each operation on a falling edge and samples the strobes 2 ns later, before the rising edge. It then reads the registers at the next falling edge, so every sample sits half a cycle away from any edge that could change it.

// File: rtl/shift_unit.sv
module shift_unit #(
  parameter int W = 32,
  localparam int FW = $clog2(W),
  localparam int CW = FW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          in_shr,
  input  logic          out_shr,
  input  logic          auto_push,
  input  logic          auto_pull,
  input  logic [FW-1:0] push_th,
  input  logic [FW-1:0] pull_th,
  input  logic [FW-1:0] in_count,
  input  logic          op_valid,
  input  logic [1:0]    op_kind,
  input  logic [FW-1:0] op_bits,
  input  logic [W-1:0]  op_data,
  input  logic          op_block,
  input  logic          op_cond,
  output logic          op_done,
  output logic          stall,
  output logic [W-1:0]  out_data,
  input  logic          rx_full,
  output logic          rx_push,
  output logic [W-1:0]  rx_data,
  input  logic          tx_empty,
  input  logic [W-1:0]  tx_data,
  output logic          tx_pull,
  output logic [W-1:0]  isr_o,
  output logic [W-1:0]  osr_o,
  output logic [CW-1:0] isr_cnt_o,
  output logic [CW-1:0] osr_cnt_o
);

  localparam logic [1:0] K_IN = 2'd0, K_OUT = 2'd1, K_PUSH = 2'd2, K_PULL = 2'd3;
  localparam logic [CW-1:0] FULL = CW'(W);

  function automatic logic [CW-1:0] widen(input logic [FW-1:0] f);
    return (f == '0) ? FULL : {1'b0, f};
  endfunction

  function automatic logic [W-1:0] lowmask(input logic [CW-1:0] k);
    if (k >= FULL) return '1;
    return (W'(1) << k) - W'(1);
  endfunction

  function automatic logic [CW-1:0] sat(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [CW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s > (CW+1)'(W)) ? FULL : s[CW-1:0];
  endfunction

  logic [W-1:0]  isr, osr, isr_d, osr_d;
  logic [CW-1:0] icnt, ocnt, icnt_d, ocnt_d;

  logic [CW-1:0] n, push_lim, pull_lim;
  assign n        = widen(op_bits);
  assign push_lim = widen(push_th);
  assign pull_lim = widen(pull_th);

  logic [W-1:0] in_bits, isr_sh;
  logic [CW-1:0] icnt_in;
  assign in_bits = op_data & lowmask(widen(in_count)) & lowmask(n);
  assign isr_sh  = (n >= FULL) ? in_bits :
                   in_shr ? ((isr >> n) | (in_bits << (FULL - n))) :
                            ((isr << n) | in_bits);
  assign icnt_in = sat(icnt, n);

  logic          pre_fill, post_fill;
  logic [W-1:0]  src, out_val, osr_sh;
  logic [CW-1:0] src_cnt, ocnt_out;
  assign pre_fill = auto_pull && (ocnt >= pull_lim);
  assign src      = pre_fill ? tx_data : osr;
  assign src_cnt  = pre_fill ? '0 : ocnt;
  assign out_val  = out_shr ? (src & lowmask(n)) :
                    (n >= FULL) ? src : (src >> (FULL - n));
  assign osr_sh   = (n >= FULL) ? '0 : (out_shr ? (src >> n) : (src << n));
  assign ocnt_out = sat(src_cnt, n);
  assign post_fill = auto_pull && !pre_fill && (ocnt_out >= pull_lim) && !tx_empty;

  always_comb begin
    isr_d    = isr;
    osr_d    = osr;
    icnt_d   = icnt;
    ocnt_d   = ocnt;
    op_done  = 1'b0;
    stall    = 1'b0;
    out_data = '0;
    rx_push  = 1'b0;
    rx_data  = isr;
    tx_pull  = 1'b0;
    if (restart) begin
      isr_d  = '0;
      icnt_d = '0;
      ocnt_d = '0;
    end else if (op_valid) begin
      case (op_kind)
        K_IN: begin
          if (auto_push && icnt_in >= push_lim) begin
            if (rx_full) stall = 1'b1;
            else begin
              rx_push = 1'b1;
              rx_data = isr_sh;
              isr_d   = '0;
              icnt_d  = '0;
              op_done = 1'b1;
            end
          end else begin
            isr_d   = isr_sh;
            icnt_d  = icnt_in;
            op_done = 1'b1;
          end
        end
        K_OUT: begin
          if (pre_fill && tx_empty) stall = 1'b1;
          else begin
            tx_pull  = pre_fill | post_fill;
            out_data = out_val;
            op_done  = 1'b1;
            if (post_fill) begin
              osr_d  = tx_data;
              ocnt_d = '0;
            end else begin
              osr_d  = osr_sh;
              ocnt_d = ocnt_out;
            end
          end
        end
        K_PUSH: begin
          if (op_cond && icnt < push_lim) op_done = 1'b1;
          else if (rx_full) begin
            if (op_block) stall = 1'b1;
            else begin
              isr_d   = '0;
              icnt_d  = '0;
              op_done = 1'b1;
            end
          end else begin
            rx_push = 1'b1;
            isr_d   = '0;
            icnt_d  = '0;
            op_done = 1'b1;
          end
        end
        default: begin
          if (op_cond && ocnt < pull_lim) op_done = 1'b1;
          else if (tx_empty) begin
            if (op_block) stall = 1'b1;
            else op_done = 1'b1;
          end else begin
            tx_pull = 1'b1;
            osr_d   = tx_data;
            ocnt_d  = '0;
            op_done = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr  <= '0;
      osr  <= '0;
      icnt <= '0;
      ocnt <= '0;
    end else begin
      isr  <= isr_d;
      osr  <= osr_d;
      icnt <= icnt_d;
      ocnt <= ocnt_d;
    end
  end

  assign isr_o     = isr;
  assign osr_o     = osr;
  assign isr_cnt_o = icnt;
  assign osr_cnt_o = ocnt;

endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk #(
  parameter int W = 32,
  localparam int CW = $clog2(W) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          restart,
  input logic          op_done,
  input logic          stall,
  input logic          rx_full,
  input logic          rx_push,
  input logic          tx_empty,
  input logic          tx_pull,
  input logic [W-1:0]  isr_o,
  input logic [W-1:0]  osr_o,
  input logic [CW-1:0] isr_cnt_o,
  input logic [CW-1:0] osr_cnt_o
);

  a_r5_push_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> (isr_o == '0) && (isr_cnt_o == '0));

  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (isr_o == $past(isr_o)) && (osr_o == $past(osr_o)) &&
              (isr_cnt_o == $past(isr_cnt_o)) && (osr_cnt_o == $past(osr_cnt_o)));

  a_r6_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !op_done && !rx_push && !tx_pull);

  a_r9_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);

  a_r9_no_pull_empty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pull |-> !tx_empty);

  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (isr_o == '0) && (isr_cnt_o == '0) && (osr_cnt_o == '0) &&
                (osr_o == $past(osr_o)));

  a_r11_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_cnt_o <= CW'(W)) && (osr_cnt_o <= CW'(W)));

endmodule

bind shift_unit shift_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .op_done(op_done), .stall(stall),
  .rx_full(rx_full), .rx_push(rx_push), .tx_empty(tx_empty), .tx_pull(tx_pull),
  .isr_o(isr_o), .osr_o(osr_o), .isr_cnt_o(isr_cnt_o), .osr_cnt_o(osr_cnt_o)
);

// File: tb/tb_shift_unit.sv
module tb_shift_unit;
  logic clk = 1'b0, rst_n = 1'b0, restart = 1'b0;
  logic in_shr = 1'b0, out_shr = 1'b0, auto_push = 1'b0, auto_pull = 1'b0;
  logic [4:0] push_th = '0, pull_th = '0, in_count = '0, op_bits = '0;
  logic op_valid = 1'b0, op_block = 1'b0, op_cond = 1'b0;
  logic [1:0] op_kind = '0;
  logic [31:0] op_data = '0, tx_data = '0;
  logic rx_full = 1'b0, tx_empty = 1'b1;
  logic op_done, stall, rx_push, tx_pull;
  logic [31:0] out_data, rx_data, isr_o, osr_o;
  logic [5:0] isr_cnt_o, osr_cnt_o;
  int checks = 0, errors = 0;

  localparam logic [1:0] IN = 2'd0, OUT = 2'd1, PUSH = 2'd2, PULL = 2'd3;

  always #4 clk = ~clk;

  shift_unit dut (.*);

  // {in_shr, in_count, op_bits, op_data, expected isr}
  localparam logic [74:0] VEC [7] = '{
    {1'b0, 5'd0, 5'd8, 32'h123456AB, 32'h000000AB},
    {1'b1, 5'd0, 5'd8, 32'h000000AB, 32'hAB000000},
    {1'b0, 5'd0, 5'd0, 32'hDEADBEEF, 32'hDEADBEEF},
    {1'b0, 5'd4, 5'd8, 32'h000000FF, 32'h0000000F},
    {1'b1, 5'd0, 5'd4, 32'h00000005, 32'h50000000},
    {1'b1, 5'd3, 5'd0, 32'hFFFFFFFF, 32'h00000007},
    {1'b0, 5'd0, 5'd1, 32'h00000001, 32'h00000001}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] k, input logic [4:0] b, input logic [31:0] d,
                       input logic blk, input logic cnd);
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; op_bits = b; op_data = d; op_block = blk; op_cond = cnd;
    #2;
  endtask

  task automatic settle();
    @(negedge clk);
    op_valid = 1'b0;
    #1;
  endtask

  task automatic do_restart();
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(isr_o, 0, "R1 isr reset");
    chk(osr_o, 0, "R1 osr reset");
    chk({26'd0, isr_cnt_o}, 0, "R1 isr count reset");
    chk({29'd0, stall, rx_push, tx_pull}, 0, "R1 strobes reset");
    rst_n = 1'b1;

    // R2 / R3 table
    for (int i = 0; i < 7; i++) begin
      do_restart();
      in_shr = VEC[i][74]; in_count = VEC[i][73:69];
      issue(IN, VEC[i][68:64], VEC[i][63:32], 1'b0, 1'b0);
      settle();
      chk(isr_o, VEC[i][31:0], $sformatf("R2 R3 vector %0d isr", i));
      chk({26'd0, isr_cnt_o}, (VEC[i][68:64] == 0) ? 32 : VEC[i][68:64],
          $sformatf("R2 vector %0d count", i));
    end
    in_count = 5'd0;

    // R2 accumulate, R11 saturation
    do_restart(); in_shr = 1'b0;
    issue(IN, 5'd8, 32'hAA, 1'b0, 1'b0); settle();
    issue(IN, 5'd8, 32'h55, 1'b0, 1'b0); settle();
    chk(isr_o, 32'hAA55, "R2 accumulate left");
    issue(IN, 5'd0, 32'h11111111, 1'b0, 1'b0); settle();
    chk({26'd0, isr_cnt_o}, 32, "R11 input count saturates");

    // R5 autopush
    do_restart(); auto_push = 1'b1; push_th = 5'd8;
    issue(IN, 5'd4, 32'hA, 1'b0, 1'b0);
    chk({31'd0, rx_push}, 0, "R5 no push below threshold");
    settle();
    issue(IN, 5'd4, 32'h5, 1'b0, 1'b0);
    chk({31'd0, rx_push}, 1, "R5 push at threshold");
    chk(rx_data, 32'hA5, "R5 pushed word");
    settle();
    chk({isr_o[25:0], isr_cnt_o}, 0, "R5 cleared after push");
    push_th = 5'd0;
    issue(IN, 5'd16, 32'h1234, 1'b0, 1'b0);
    chk({31'd0, rx_push}, 0, "R5 threshold 0 is 32, no push at 16");
    settle();
    issue(IN, 5'd16, 32'h5678, 1'b0, 1'b0);
    chk(rx_data, 32'h12345678, "R5 push at 32");
    chk({31'd0, rx_push}, 1, "R5 push strobe at 32");
    settle();

    // R6 autopush stall on full
    push_th = 5'd8;
    issue(IN, 5'd4, 32'h3, 1'b0, 1'b0); settle();
    rx_full = 1'b1;
    issue(IN, 5'd4, 32'h9, 1'b0, 1'b0);
    chk({30'd0, stall, op_done}, 32'b10, "R6 stall on full");
    settle();
    chk({26'd0, isr_cnt_o}, 4, "R6 count unchanged");
    chk(isr_o, 32'h3, "R6 isr unchanged");
    rx_full = 1'b0;
    issue(IN, 5'd4, 32'h9, 1'b0, 1'b0);
    chk(rx_data, 32'h39, "R6 push after release");
    settle();
    auto_push = 1'b0;

    // R4 / R9 pull and shift out
    tx_empty = 1'b0; tx_data = 32'h12345678; out_shr = 1'b1;
    issue(PULL, 5'd0, 0, 1'b1, 1'b0); settle();
    chk(osr_o, 32'h12345678, "R9 pull loads");
    issue(OUT, 5'd8, 0, 1'b0, 1'b0);
    chk(out_data, 32'h78, "R4 right out from LSB");
    settle();
    chk(osr_o, 32'h00123456, "R4 right shift");
    chk({26'd0, osr_cnt_o}, 8, "R4 count");
    issue(PULL, 5'd0, 0, 1'b1, 1'b0); settle();
    out_shr = 1'b0;
    issue(OUT, 5'd8, 0, 1'b0, 1'b0);
    chk(out_data, 32'h12, "R4 left out from MSB");
    settle();
    chk(osr_o, 32'h34567800, "R4 left shift");
    issue(OUT, 5'd0, 0, 1'b0, 1'b0);
    chk(out_data, 32'h34567800, "R4 out 32 bits");
    settle();
    issue(OUT, 5'd4, 0, 1'b0, 1'b0);
    chk(out_data, 0, "R4 out of empty register");
    settle();
    chk({26'd0, osr_cnt_o}, 32, "R11 output count saturates");

    // R7 autopull
    tx_data = 32'hAABBCCDD;
    issue(PULL, 5'd0, 0, 1'b1, 1'b0); settle();
    auto_pull = 1'b1; pull_th = 5'd8; out_shr = 1'b1; tx_data = 32'h11223344;
    issue(OUT, 5'd8, 0, 1'b0, 1'b0);
    chk(out_data, 32'hDD, "R7 out before refill");
    chk({31'd0, tx_pull}, 1, "R7 refill strobe");
    settle();
    chk(osr_o, 32'h11223344, "R7 refilled word");
    chk({26'd0, osr_cnt_o}, 0, "R7 count zero after refill");
    tx_empty = 1'b1;
    issue(OUT, 5'd8, 0, 1'b0, 1'b0);
    chk({30'd0, op_done, tx_pull}, 32'b10, "R7 completes without refill");
    settle();
    issue(OUT, 5'd8, 0, 1'b0, 1'b0);
    chk({31'd0, stall}, 1, "R7 stall on empty at threshold");
    settle();
    chk(osr_o, 32'h00112233, "R7 osr held during stall");
    tx_empty = 1'b0; tx_data = 32'hCAFEF00D;
    issue(OUT, 5'd8, 0, 1'b0, 1'b0);
    chk(out_data, 32'h0D, "R7 shift from fresh word");
    settle();
    chk(osr_o, 32'h00CAFEF0, "R7 after late refill");
    auto_pull = 1'b0;

    // R8 conditional
    do_restart(); push_th = 5'd8;
    issue(IN, 5'd4, 32'h3, 1'b0, 1'b0); settle();
    issue(PUSH, 5'd0, 0, 1'b1, 1'b1);
    chk({30'd0, op_done, rx_push}, 32'b10, "R8 conditional push below threshold");
    settle();
    chk({26'd0, isr_cnt_o}, 4, "R8 input kept");
    issue(IN, 5'd4, 32'hC, 1'b0, 1'b0); settle();
    issue(PUSH, 5'd0, 0, 1'b1, 1'b1);
    chk(rx_data, 32'h3C, "R8 conditional push at threshold");
    settle();
    tx_data = 32'h0BADBEEF;
    issue(PULL, 5'd0, 0, 1'b1, 1'b0); settle();
    tx_data = 32'h77777777;
    issue(PULL, 5'd0, 0, 1'b1, 1'b1);
    chk({31'd0, tx_pull}, 0, "R8 conditional pull below threshold");
    settle();
    chk(osr_o, 32'h0BADBEEF, "R8 osr kept");

    // R9 blocking / non-blocking
    issue(IN, 5'd4, 32'h6, 1'b0, 1'b0); settle();
    rx_full = 1'b1;
    issue(PUSH, 5'd0, 0, 1'b1, 1'b0);
    chk({31'd0, stall}, 1, "R9 blocking push stalls");
    settle();
    chk(isr_o, 32'h6, "R9 isr kept while blocked");
    issue(PUSH, 5'd0, 0, 1'b0, 1'b0);
    chk({29'd0, stall, op_done, rx_push}, 32'b010, "R9 non-blocking push drops");
    settle();
    chk({isr_o[25:0], isr_cnt_o}, 0, "R9 dropped push clears input");
    rx_full = 1'b0; tx_empty = 1'b1;
    issue(PULL, 5'd0, 0, 1'b1, 1'b0);
    chk({31'd0, stall}, 1, "R9 blocking pull stalls");
    settle();
    issue(PULL, 5'd0, 0, 1'b0, 1'b0);
    chk({30'd0, stall, op_done}, 32'b01, "R9 non-blocking pull completes");
    settle();
    chk(osr_o, 32'h0BADBEEF, "R9 non-blocking pull keeps osr");
    tx_empty = 1'b0;

    // R10 restart
    issue(IN, 5'd8, 32'h5A, 1'b0, 1'b0); settle();
    out_shr = 1'b1;
    issue(OUT, 5'd4, 0, 1'b0, 1'b0); settle();
    @(negedge clk);
    restart = 1'b1; op_valid = 1'b1; op_kind = IN; op_bits = 5'd8; op_data = 32'hFF;
    #2;
    chk({31'd0, op_done}, 0, "R10 restart overrides op");
    @(negedge clk);
    restart = 1'b0; op_valid = 1'b0;
    #1;
    chk(isr_o, 0, "R10 isr cleared");
    chk({20'd0, isr_cnt_o, osr_cnt_o}, 0, "R10 counters cleared");
    chk(osr_o, 32'h00BADBEE, "R10 osr kept");

    finish_run();
  end
endmodule